// File: doc/BRIEF.md
# Terminal Character Transmit Controller

This block is the output side of a programmed-I/O character terminal port. The host writes a byte into a one-character holding register with a data-out strobe. It then fires a start pulse. The block marks itself busy and runs a programmable character-time countdown. When the countdown expires, it drops busy, raises done, and requests an interrupt unless the port's interrupt mask is set. At the same moment it presents the character on a byte-stream output that uses a valid/ready handshake.

Only the low seven bits of the held byte are sent. When the terminal-mode input is high, the control code 0x19 goes out as backspace (0x08). A clear pulse aborts everything: busy, done, the interrupt request, any countdown in progress, and any character waiting on the output. A character that cannot be handed to the output because the previous one is still waiting is never dropped. Completion waits until the output can take it.

Top module: `term_tx_ctrl`

## Requirements
- R1: After reset, busy, done, irq and out_valid are 0 and the holding register is 0x00, so a start with no prior load transmits 0x00.
- R2: A load strobe copies bits [7:0] of the accumulator input into the holding register; the transmitted byte is that register ANDed with 0x7F, so out_data[7] is always 0.
- R3: A start pulse (without clear) makes busy 1, done 0 and irq 0 from the next cycle, including when done was already set.
- R4: With delay value N sampled at the start pulse, done rises on the clock edge N+1 edges after the start edge; N = 0 gives done on the very next edge.
- R5: On completion busy becomes 0, done becomes 1, and irq becomes 1 exactly when the mask input is 0 at that edge.
- R6: A clear pulse makes busy, done, irq and out_valid 0 on the next cycle and cancels a running countdown, so no completion follows it.
- R7: When clear and start are pulsed in the same cycle, clear wins.
- R8: With terminal mode 1, a masked code of 0x19 is sent as 0x08 (this includes a held byte of 0x99); with mode 0, or for any other code, the masked byte is sent unchanged.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays stable; a byte is consumed on an edge where both are 1.
- R10: If the countdown has expired but the previous byte is still waiting unaccepted, completion is postponed (busy stays 1, done stays 0) until the output can take the new byte; no byte is lost.
- R11: irq is registered at completion; changing the mask afterwards leaves irq unchanged until the next start or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_strobe | input | 1 | Load holding register from acc_in |
| acc_in | input | ACC_W | Accumulator word; low byte is used |
| start_pulse | input | 1 | Begin a transfer |
| clear_pulse | input | 1 | Abort and clear flags |
| delay_cycles | input | DLY_W | Character-time countdown value |
| term_mode | input | 1 | 1 = remap 0x19 to backspace |
| irq_mask | input | 1 | 1 = suppress interrupt request |
| out_valid | output | 1 | Byte available on out_data |
| out_ready | input | 1 | Sink accepts byte |
| out_data | output | 8 | Transmitted byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete |
| irq | output | 1 | Interrupt request |

## Verification
A countdown register that is off by one shows up as done rising one edge early or late against the N+1 count. The bench measures that count to the edge for several delay values. A slot that loses its state shows within one cycle as out_valid falling or out_data changing while out_ready is low. A cancel that does not reach the countdown shows as a late done, long after busy had been cleared. A wrong remap or mask path shows on the first byte that carries the affected code.

// File: rtl/tto_pkg.sv
package tto_pkg;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] CODE_EM = 8'h19;
  localparam logic [CHAR_W-1:0] CODE_BS = 8'h08;

  // Byte that goes on the wire for a held byte and mode.
  function automatic logic [CHAR_W-1:0] tto_render(input logic [CHAR_W-1:0] held,
                                                   input logic mode);
    logic [CHAR_W-1:0] c;
    c = held & 8'h7F;
    if (mode && (c == CODE_EM)) c = CODE_BS;
    return c;
  endfunction
endpackage

// File: rtl/tto_delay.sv
module tto_delay #(
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             cancel,
  input  logic [DLY_W-1:0] load_val,
  input  logic             can_fire,
  output logic             fire
);
  logic             armed_q;
  logic [DLY_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign fire    = armed_q && at_zero && can_fire && !arm && !cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cancel) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm) begin
      armed_q <= 1'b1;
      cnt_q   <= load_val;
    end else if (fire) begin
      armed_q <= 1'b0;
    end else if (armed_q && !at_zero) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tto_slot.sv
module tto_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         can_take
);
  assign can_take = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (push) begin
      valid <= 1'b1;
      data  <= push_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/term_tx_ctrl.sv
module term_tx_ctrl #(
  parameter int ACC_W = 16,
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_strobe,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             start_pulse,
  input  logic             clear_pulse,
  input  logic [DLY_W-1:0] delay_cycles,
  input  logic             term_mode,
  input  logic             irq_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             busy,
  output logic             done,
  output logic             irq
);
  import tto_pkg::*;

  logic [CHAR_W-1:0] hold_q;
  logic              clear_evt;
  logic              start_evt;
  logic              complete_evt;
  logic              slot_free;
  logic [CHAR_W-1:0] wire_char;

  assign clear_evt = clear_pulse;
  assign start_evt = start_pulse && !clear_pulse;
  assign wire_char = tto_render(hold_q, term_mode);

  tto_delay #(.DLY_W(DLY_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (start_evt),
    .cancel   (clear_evt),
    .load_val (delay_cycles),
    .can_fire (slot_free),
    .fire     (complete_evt)
  );

  tto_slot #(.W(CHAR_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (clear_evt),
    .push      (complete_evt),
    .push_data (wire_char),
    .ready     (out_ready),
    .valid     (out_valid),
    .data      (out_data),
    .can_take  (slot_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (load_strobe) hold_q <= acc_in[CHAR_W-1:0];
      if (clear_evt) begin
        busy <= 1'b0;
        done <= 1'b0;
        irq  <= 1'b0;
      end else if (start_evt) begin
        busy <= 1'b1;
        done <= 1'b0;
        irq  <= 1'b0;
      end else if (complete_evt) begin
        busy <= 1'b0;
        done <= 1'b1;
        irq  <= !irq_mask;
      end
    end
  end
endmodule

// File: rtl/term_tx_ctrl_chk.sv
module term_tx_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_pulse,
  input logic       clear_pulse,
  input logic       complete_evt,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       busy,
  input logic       done,
  input logic       irq
);
  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !clear_pulse) |=> (busy && !done && !irq));
  // R6
  clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |=> (!busy && !done && !irq && !out_valid));
  // R5
  complete_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    complete_evt |=> (done && !busy));
  // R5
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear_pulse) |=> (out_valid && $stable(out_data)));
  // R2
  seven_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_data[7]);
endmodule

bind term_tx_ctrl term_tx_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_pulse  (start_pulse),
  .clear_pulse  (clear_pulse),
  .complete_evt (complete_evt),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .busy         (busy),
  .done         (done),
  .irq          (irq)
);

// File: tb/sim_term_tx_ctrl.sv
module sim_term_tx_ctrl;
  localparam time CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_strobe = 1'b0;
  logic [15:0] acc_in = '0;
  logic        start_pulse = 1'b0;
  logic        clear_pulse = 1'b0;
  logic [23:0] delay_cycles = '0;
  logic        term_mode = 1'b0;
  logic        irq_mask = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        busy, done, irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_tx_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .load_strobe(load_strobe), .acc_in(acc_in),
    .start_pulse(start_pulse), .clear_pulse(clear_pulse),
    .delay_cycles(delay_cycles), .term_mode(term_mode), .irq_mask(irq_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .done(done), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] acc;
    logic        mode;
    logic        mask;
    logic [7:0]  wait_n;
    logic [7:0]  exp_char;
    logic        exp_irq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'h1241, 1'b0, 1'b0, 8'd3, 8'h41, 1'b1},
    '{16'h00C1, 1'b0, 1'b0, 8'd0, 8'h41, 1'b1},
    '{16'h0019, 1'b1, 1'b0, 8'd2, 8'h08, 1'b1},
    '{16'h0019, 1'b0, 1'b1, 8'd1, 8'h19, 1'b0},
    '{16'hAB99, 1'b1, 1'b0, 8'd5, 8'h08, 1'b1},
    '{16'h0008, 1'b1, 1'b1, 8'd4, 8'h08, 1'b0},
    '{16'h007F, 1'b1, 1'b0, 8'd7, 8'h7F, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_load(input logic [15:0] v);
    acc_in = v; load_strobe = 1'b1; tick(); load_strobe = 1'b0;
  endtask

  task automatic do_start(input logic [23:0] n);
    delay_cycles = n; start_pulse = 1'b1; tick(); start_pulse = 1'b0;
  endtask

  task automatic do_clear();
    clear_pulse = 1'b1; tick(); clear_pulse = 1'b0;
  endtask

  // ticks from first post-start negedge until done is seen
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 300) begin tick(); n++; end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected <= %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] first_c;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 irq", irq, 0);
    check("R1 out_valid", out_valid, 0);
    // R1 holding register cleared: start without load sends 0x00
    do_start(0);
    wait_done(n);
    check("R1 zero byte", out_data, 8'h00);
    tick();

    // table walk: R2 R4 R5 R8
    foreach (VECS[i]) begin
      term_mode = VECS[i].mode;
      irq_mask  = VECS[i].mask;
      do_load(VECS[i].acc);
      do_start({16'h0, VECS[i].wait_n});
      check("R3 busy after start", busy, 1);
      wait_done(n);
      check("R4 delay count", n, VECS[i].wait_n + 1);
      check("R5 busy cleared", busy, 0);
      check("R5 irq vs mask", irq, VECS[i].exp_irq);
      check("R9 valid at done", out_valid, 1);
      check("R2/R8 byte", out_data, VECS[i].exp_char);
      tick();
      check("R9 consumed", out_valid, 0);
    end
    irq_mask = 1'b0; term_mode = 1'b0;

    // R11 irq registered
    do_load(16'h0041); do_start(1); wait_done(n);
    check("R11 irq set", irq, 1);
    irq_mask = 1'b1; tick(); tick();
    check("R11 irq held", irq, 1);
    irq_mask = 1'b0;
    // R3 start when done already set
    do_start(4);
    check("R3 done cleared", done, 0);
    check("R3 irq cleared", irq, 0);
    wait_done(n);
    tick();

    // R6 clear mid-countdown
    do_start(10);
    tick(); tick(); tick();
    do_clear();
    check("R6 busy", busy, 0);
    check("R6 done", done, 0);
    n = 0;
    for (int k = 0; k < 25; k++) begin
      if (done || out_valid) n++;
      tick();
    end
    check("R6 no completion", n, 0);

    // R7 clear and start together
    start_pulse = 1'b1; clear_pulse = 1'b1; delay_cycles = 0; tick();
    start_pulse = 1'b0; clear_pulse = 1'b0;
    check("R7 busy", busy, 0);
    tick(); tick();
    check("R7 done", done, 0);

    // R9 hold and R10 retry
    out_ready = 1'b0;
    do_load(16'h0033); do_start(0); wait_done(n);
    first_c = out_data;
    check("R9 first byte", first_c, 8'h33);
    tick(); tick(); tick();
    check("R9 held valid", out_valid, 1);
    check("R9 held data", out_data, 8'h33);
    do_load(16'h0055); do_start(0);
    tick(); tick(); tick();
    check("R10 still busy", busy, 1);
    check("R10 not done", done, 0);
    check("R10 old byte kept", out_data, 8'h33);
    out_ready = 1'b1; tick();
    check("R10 done after free", done, 1);
    check("R10 new byte", out_data, 8'h55);
    check("R10 valid", out_valid, 1);
    tick();
    check("R9 drained", out_valid, 0);

    // R6 clear flushes a waiting byte
    out_ready = 1'b0;
    do_load(16'h0021); do_start(0); wait_done(n);
    check("R6 pre valid", out_valid, 1);
    do_clear();
    check("R6 flushed", out_valid, 0);
    out_ready = 1'b1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule